// File: doc/BRIEF.md
# Link Phase Scan Controller

This block tunes the sampling phase of a clocked board-to-board link without any outside stimulus. It walks a delay-line code through every setting that fits in one period of the base clock. The default is 13 settings, since a 25 ns period stepped in 2 ns increments gives about 12 to 13. At each setting it fires a test-pattern inject strobe and collects a pass/fail verdict from the receiving checker. It then keeps the centre of the widest run of passing settings. The run is measured around the period boundary, so a window that straddles the last and first codes counts as one stretch.

For a receive-only link it scans a single axis, the receive code. For a bidirectional link it works the two-dimensional space in the required order. It optimises the transmit code first, holding the receive code where it stands. It then scans the receive code with the transmit code fixed at its new value. Because a receive setting near the clock boundary can open a metastable hole, the transmit/receive pair is repeated a parameterised number of rounds. Each round starts from the previous round's answers.

Software or a sequencer pulses `start` and waits for `done`. The chosen codes stay on the outputs until the next start. If any scan finds no passing setting, the block stops at once and raises `err` with `done`, and both codes are left at zero.

Top module: `lps_scan_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `inject` are low, and both `tx_code` and `rx_code` are zero.
- R2: A `start` pulse sampled while idle begins a scan, and `busy` is high from the next cycle. `start` is ignored while `busy` is high, and the mode and trial count latched at the accepted start are kept.
- R3: Within a scan the active axis code takes the values 0, 1, … N_TAPS-1 in order. Each value is held for SETTLE_CYC cycles before its first `inject`. `inject` is a one-cycle pulse per trial. The next trial's `inject` comes in the cycle after the response with `cmp_valid` high is taken, and one cycle separates the last response of a setting from the next setting.
- R4: A setting passes only if every one of its `trials` responses reports `cmp_ok` high. A `trials` value of 0 is treated as 1.
- R5: The result of a scan is taken from the longest run of passing settings, counted circularly. Settings N_TAPS-1 and 0 are neighbours, so a window across the boundary is one run.
- R6: The chosen code is (first + (length-1)/2) mod N_TAPS. On equal lengths, the run whose first setting has the lowest index wins. If every setting passes, the code is (N_TAPS-1)/2.
- R7: With `two_d` low at start, only the receive code is scanned and `tx_code` stays 0 throughout.
- R8: With `two_d` high at start, the transmit code is scanned first, with the receive code held (0 in round one). Then the receive code is scanned with the transmit code held at its new pick. This pair repeats ROUNDS times.
- R9: If any scan has no passing setting, the run ends right after that scan. `done` rises with `err` high, and both codes are zero.
- R10: `done` is a one-cycle pulse during which `busy` is low. The codes and `err` then hold until the next accepted start, and `err` clears when a new scan starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (taken only when idle) |
| two_d | input | 1 | 1: transmit then receive scan; 0: receive only |
| trials | input | TRIAL_W | Trials per setting (0 acts as 1) |
| cmp_valid | input | 1 | Compare result present this cycle |
| cmp_ok | input | 1 | Compare result: pattern arrived intact |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last run found no passing setting |
| inject | output | 1 | Fire one test pattern |
| tx_code | output | $clog2(N_TAPS) | Transmit delay-line code |
| rx_code | output | $clog2(N_TAPS) | Receive delay-line code |

## Verification
The properties assume the pattern checker answers each inject with exactly one `cmp_valid` pulse, and sends no response that was not asked for. Under that assumption, inject exclusivity and the done handshake can be judged from the ports alone. The stimulus keeps within this by modelling the link as a fixed-latency echo of `inject`. The echo's verdict comes from per-test pass windows over the current codes, optionally coupling transmit and receive or failing one setting on its second trial. The bench pulses `start` only while idle, except for one deliberate pulse mid-scan.

// File: rtl/lps_pkg.sv
package lps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETTLE,
      ST_INJECT,
      ST_WAIT,
      ST_NEXT,
      ST_PICK,
      ST_FIN
   } lps_state_e;

   typedef enum logic {
      AX_TX = 1'b0,
      AX_RX = 1'b1
   } lps_axis_e;

endpackage

// File: rtl/lps_settle_timer.sv
module lps_settle_timer #(
   parameter int SETTLE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   generate
      if (SETTLE_CYC == 1) begin : g_single
         assign expired = run;
      end else begin : g_count
         localparam int SW = $clog2(SETTLE_CYC);
         logic [SW-1:0] cnt_q;

         assign expired = run && (cnt_q == SW'(SETTLE_CYC - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || expired) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + SW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/lps_trial_gate.sv
module lps_trial_gate #(
   parameter int TRIAL_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               rsp_valid,
   input  logic               rsp_ok,
   input  logic [TRIAL_W-1:0] trials,
   output logic               last,
   output logic               verdict
);

   localparam int CNT_W = TRIAL_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] goal;
   logic             fail_q;

   // a zero trial count still runs one trial
   assign goal    = (trials == '0) ? CNT_W'(1) : {1'b0, trials};
   assign last    = rsp_valid && ((cnt_q + CNT_W'(1)) == goal);
   assign verdict = !fail_q && rsp_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else if (clear) begin
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else if (rsp_valid) begin
         cnt_q  <= cnt_q + CNT_W'(1);
         fail_q <= fail_q | ~rsp_ok;
      end
   end

endmodule

// File: rtl/lps_window_pick.sv
module lps_window_pick #(
   parameter int N_TAPS = 13,
   parameter int CW     = $clog2(N_TAPS)
) (
   input  logic [N_TAPS-1:0] mask,
   output logic              any_pass,
   output logic [CW-1:0]     centre
);

   int   best_len;
   int   best_start;
   int   run_len;
   logic stop;
   logic all_pass;

   assign any_pass = |mask;
   assign all_pass = &mask;

   always_comb begin
      best_len   = 0;
      best_start = 0;
      for (int s = 0; s < N_TAPS; s++) begin
         run_len = 0;
         stop    = 1'b0;
         for (int k = 0; k < N_TAPS; k++) begin
            if (!stop && mask[CW'((s + k) % N_TAPS)]) begin
               run_len = run_len + 1;
            end else begin
               stop = 1'b1;
            end
         end
         // a run begins where a pass follows a fail (circularly)
         if (mask[CW'(s)] && (all_pass || !mask[CW'((s + N_TAPS - 1) % N_TAPS)])
             && (run_len > best_len)) begin
            best_len   = run_len;
            best_start = s;
         end
      end
      centre = CW'((best_start + (best_len - 1) / 2) % N_TAPS);
   end

endmodule

// File: rtl/lps_scan_ctrl.sv
module lps_scan_ctrl
   import lps_pkg::*;
#(
   parameter int N_TAPS     = 13,
   parameter int TRIAL_W    = 4,
   parameter int SETTLE_CYC = 2,
   parameter int ROUNDS     = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      two_d,
   input  logic [TRIAL_W-1:0]        trials,
   input  logic                      cmp_valid,
   input  logic                      cmp_ok,
   output logic                      busy,
   output logic                      done,
   output logic                      err,
   output logic                      inject,
   output logic [$clog2(N_TAPS)-1:0] tx_code,
   output logic [$clog2(N_TAPS)-1:0] rx_code
);

   localparam int CW = $clog2(N_TAPS);
   localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

   generate
      if (N_TAPS < 2) begin : g_bad_taps
         $error("lps_scan_ctrl: N_TAPS must be at least 2");
      end
      if (TRIAL_W < 1) begin : g_bad_trial
         $error("lps_scan_ctrl: TRIAL_W must be at least 1");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("lps_scan_ctrl: SETTLE_CYC must be at least 1");
      end
      if (ROUNDS < 1) begin : g_bad_rounds
         $error("lps_scan_ctrl: ROUNDS must be at least 1");
      end
   endgenerate

   lps_state_e          state_q;
   lps_axis_e           axis_q;
   logic [CW-1:0]       tap_q;
   logic [N_TAPS-1:0]   mask_q;
   logic [CW-1:0]       tx_q;
   logic [CW-1:0]       rx_q;
   logic                mode_q;
   logic [TRIAL_W-1:0]  trials_q;
   logic [RW-1:0]       round_q;
   logic                err_q;

   logic                settle_done;
   logic                trial_last;
   logic                trial_verdict;
   logic                win_any;
   logic [CW-1:0]       win_centre;
   logic                last_tap;
   logic                last_round;

   lps_settle_timer #(
      .SETTLE_CYC (SETTLE_CYC)
   ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_SETTLE),
      .expired (settle_done)
   );

   lps_trial_gate #(
      .TRIAL_W (TRIAL_W)
   ) u_trials (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (state_q == ST_SETTLE),
      .rsp_valid ((state_q == ST_WAIT) && cmp_valid),
      .rsp_ok    (cmp_ok),
      .trials    (trials_q),
      .last      (trial_last),
      .verdict   (trial_verdict)
   );

   lps_window_pick #(
      .N_TAPS (N_TAPS),
      .CW     (CW)
   ) u_pick (
      .mask     (mask_q),
      .any_pass (win_any),
      .centre   (win_centre)
   );

   assign last_tap   = (tap_q == CW'(N_TAPS - 1));
   assign last_round = (round_q == RW'(ROUNDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         axis_q   <= AX_RX;
         tap_q    <= '0;
         mask_q   <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         mode_q   <= 1'b0;
         trials_q <= '0;
         round_q  <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  mode_q   <= two_d;
                  trials_q <= trials;
                  axis_q   <= two_d ? AX_TX : AX_RX;
                  tap_q    <= '0;
                  mask_q   <= '0;
                  tx_q     <= '0;
                  rx_q     <= '0;
                  round_q  <= '0;
                  err_q    <= 1'b0;
                  state_q  <= ST_SETTLE;
               end
            end
            ST_SETTLE: begin
               if (settle_done) begin
                  state_q <= ST_INJECT;
               end
            end
            ST_INJECT: begin
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (cmp_valid) begin
                  if (trial_last) begin
                     mask_q[tap_q] <= trial_verdict;
                     state_q       <= ST_NEXT;
                  end else begin
                     state_q <= ST_INJECT;
                  end
               end
            end
            ST_NEXT: begin
               if (last_tap) begin
                  state_q <= ST_PICK;
               end else begin
                  tap_q   <= tap_q + CW'(1);
                  state_q <= ST_SETTLE;
               end
            end
            ST_PICK: begin
               tap_q  <= '0;
               mask_q <= '0;
               if (!win_any) begin
                  err_q   <= 1'b1;
                  tx_q    <= '0;
                  rx_q    <= '0;
                  state_q <= ST_FIN;
               end else if (axis_q == AX_TX) begin
                  tx_q    <= win_centre;
                  axis_q  <= AX_RX;
                  state_q <= ST_SETTLE;
               end else begin
                  rx_q <= win_centre;
                  if (mode_q && !last_round) begin
                     round_q <= round_q + RW'(1);
                     axis_q  <= AX_TX;
                     state_q <= ST_SETTLE;
                  end else begin
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy    = (state_q != ST_IDLE) && (state_q != ST_FIN);
   assign done    = (state_q == ST_FIN);
   assign err     = err_q;
   assign inject  = (state_q == ST_INJECT);
   assign tx_code = (busy && (axis_q == AX_TX)) ? tap_q : tx_q;
   assign rx_code = (busy && (axis_q == AX_RX)) ? tap_q : rx_q;

endmodule

// File: rtl/lps_scan_checker.sv
module lps_scan_checker #(
   parameter int N_TAPS = 13,
   parameter int CW     = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          inject,
   input logic [CW-1:0] tx_code,
   input logic [CW-1:0] rx_code,
   input logic          mode_lat
);

   assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> busy);

   assert_inject_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inject |-> busy);

   assert_inject_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inject |=> !inject);

   assert_code_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tx_code) < N_TAPS) && (int'(rx_code) < N_TAPS));

   assert_tx_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mode_lat) |-> (tx_code == '0));

   assert_err_zero_codes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ((tx_code == '0) && (rx_code == '0)));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && !start) |=> ($stable(tx_code) && $stable(rx_code) && $stable(err)));

endmodule

bind lps_scan_ctrl lps_scan_checker #(
   .N_TAPS (N_TAPS),
   .CW     (CW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .done     (done),
   .err      (err),
   .inject   (inject),
   .tx_code  (tx_code),
   .rx_code  (rx_code),
   .mode_lat (mode_q)
);

// File: tb/lps_scan_ctrl_tb.sv
module lps_scan_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NT  = 13;
   localparam int CW  = 4;
   localparam int ST  = 2;
   localparam int RND = 2;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic two_d = 1'b0;
   logic [3:0] trials = 4'd1;
   logic cmp_valid;
   logic cmp_ok;
   logic busy, done, err, inject;
   logic [CW-1:0] tx_code, rx_code;

   int n_chk = 0;
   int n_fail = 0;

   // link emulation knobs
   logic [NT-1:0] tx_m = '1;
   logic [NT-1:0] rx_m = '1;
   bit couple = 1'b0;
   int flaky_rx = -1;

   // expectations for the current cycle
   logic e_busy = 1'b0, e_inj = 1'b0, e_done = 1'b0, e_err = 1'b0;
   logic [CW-1:0] e_tx = '0, e_rx = '0;
   bit ls_on = 1'b0;
   bit poke_now = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lps_scan_ctrl #(
      .N_TAPS     (NT),
      .TRIAL_W    (4),
      .SETTLE_CYC (ST),
      .ROUNDS     (RND)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .two_d     (two_d),
      .trials    (trials),
      .cmp_valid (cmp_valid),
      .cmp_ok    (cmp_ok),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .inject    (inject),
      .tx_code   (tx_code),
      .rx_code   (rx_code)
   );

   function automatic bit link_base(int tx, int rx);
      bit t;
      t = couple ? tx_m[(tx + rx) % NT] : tx_m[tx];
      return t && rx_m[rx];
   endfunction

   function automatic bit link_ok(int tx, int rx, int nth);
      if (rx == flaky_rx && nth == 2) return 1'b0;
      return link_base(tx, rx);
   endfunction

   function automatic bit model_pass(int tx, int rx, int eff);
      if (rx == flaky_rx && eff >= 2) return 1'b0;
      return link_base(tx, rx);
   endfunction

   function automatic int model_pick(logic [NT-1:0] m);
      int best = 0;
      int bs = -1;
      if (m == '1) return (NT - 1) / 2;
      for (int s = 0; s < NT; s++) begin
         if (m[s] && !m[(s + NT - 1) % NT]) begin
            int len = 0;
            while (len < NT && m[(s + len) % NT]) len++;
            if (len > best) begin
               best = len;
               bs = s;
            end
         end
      end
      if (bs < 0) return -1;
      return (bs + (best - 1) / 2) % NT;
   endfunction

   function automatic logic [NT-1:0] win(int lo, int len);
      logic [NT-1:0] v = '0;
      for (int i = 0; i < len; i++) v[(lo + i) % NT] = 1'b1;
      return v;
   endfunction

   // link echo: one response LAT cycles after each inject
   logic [LAT-1:0] inj_pipe;
   int since;
   int nth;
   always @(posedge clk) begin
      if (!rst_n) begin
         inj_pipe <= '0;
         since <= 100;
         nth <= 0;
      end else begin
         inj_pipe <= {inj_pipe[LAT-2:0], inject};
         if (inject) begin
            nth <= (since > LAT + 1) ? 1 : nth + 1;
            since <= 1;
         end else if (since < 100) begin
            since <= since + 1;
         end
      end
   end
   assign cmp_valid = inj_pipe[LAT-1];
   assign cmp_ok = cmp_valid && link_ok(int'(tx_code), int'(rx_code), nth);

   // lockstep comparison against the model, every cycle
   always @(negedge clk) begin
      if (ls_on) begin
         n_chk++;
         if (inject !== e_inj) begin
            n_fail++;
            $display("FAIL R3 inject at %0t: actual=%b expected=%b", $time, inject, e_inj);
         end else if (busy !== e_busy || done !== e_done) begin
            n_fail++;
            $display("FAIL R10 busy/done at %0t: actual=%b%b expected=%b%b",
                     $time, busy, done, e_busy, e_done);
         end else if (err !== e_err) begin
            n_fail++;
            $display("FAIL R9 err at %0t: actual=%b expected=%b", $time, err, e_err);
         end else if (tx_code !== e_tx || rx_code !== e_rx) begin
            n_fail++;
            $display("FAIL R8 codes at %0t: actual=%0d/%0d expected=%0d/%0d",
                     $time, tx_code, rx_code, e_tx, e_rx);
         end
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(bit b, bit i, bit d, bit e, int tx, int rx);
      e_busy = b;
      e_inj = i;
      e_done = d;
      e_err = e;
      e_tx = CW'(tx);
      e_rx = CW'(rx);
      if (poke_now) begin
         start = 1'b1;
         two_d = ~two_d;
      end
      poke_now = 1'b0;
      @(posedge clk);
      #1 start = 1'b0;
   endtask

   task automatic run_scan(bit md, int ntr, bit poke);
      int eff = (ntr == 0) ? 1 : ntr;
      int nsc = md ? 2 * RND : 1;
      int txv = 0;
      int rxv = 0;
      bit bad = 1'b0;
      @(negedge clk);
      start = 1'b1;
      two_d = md;
      trials = 4'(ntr);
      @(posedge clk);
      #1 start = 1'b0;
      for (int sc = 0; sc < nsc && !bad; sc++) begin
         bit is_tx = md && (sc % 2 == 0);
         logic [NT-1:0] m = '0;
         int c;
         for (int tap = 0; tap < NT; tap++) begin
            int te = is_tx ? tap : txv;
            int re = is_tx ? rxv : tap;
            for (int k = 0; k < ST; k++) begin
               poke_now = poke && sc == 0 && tap == 1 && k == 0;
               cyc(1, 0, 0, 0, te, re);
            end
            for (int t = 0; t < eff; t++) begin
               cyc(1, 1, 0, 0, te, re);
               for (int w = 0; w < LAT; w++) cyc(1, 0, 0, 0, te, re);
            end
            cyc(1, 0, 0, 0, te, re);
            m[tap] = model_pass(te, re, eff);
         end
         cyc(1, 0, 0, 0, is_tx ? NT - 1 : txv, is_tx ? rxv : NT - 1);
         c = model_pick(m);
         if (c < 0) bad = 1'b1;
         else if (is_tx) txv = c;
         else rxv = c;
      end
      if (bad) begin
         txv = 0;
         rxv = 0;
      end
      cyc(0, 0, 1, bad, txv, rxv);
      e_done = 1'b0;
      @(posedge clk);
      #1;
      @(posedge clk);
      #1;
   endtask

   task automatic finish_up();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_up();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 err", int'(err), 0);
      chk("R1 inject", int'(inject), 0);
      chk("R1 tx_code", int'(tx_code), 0);
      chk("R1 rx_code", int'(rx_code), 0);
      rst_n = 1'b1;
      ls_on = 1'b1;
      @(posedge clk);
      #1;

      // R5 R7: plain receive-only window
      rx_m = win(3, 6);
      run_scan(0, 1, 0);
      chk("R5 rx centre", int'(rx_code), 5);
      chk("R7 tx parked", int'(tx_code), 0);

      // R5: window across the boundary beats a shorter one
      rx_m = win(10, 6) | win(5, 2);
      run_scan(0, 1, 0);
      chk("R5 wrapped centre", int'(rx_code), 12);

      // R6: tie goes to lowest start
      rx_m = win(1, 3) | win(7, 3);
      run_scan(0, 2, 0);
      chk("R6 tie centre", int'(rx_code), 2);

      // R6: every setting passes
      rx_m = '1;
      run_scan(0, 1, 0);
      chk("R6 all pass centre", int'(rx_code), 6);

      // R9: nothing passes
      rx_m = '0;
      run_scan(0, 1, 0);
      chk("R9 err", int'(err), 1);
      chk("R9 rx zero", int'(rx_code), 0);

      // R4: second-trial failure at setting 5
      rx_m = win(3, 6);
      flaky_rx = 5;
      run_scan(0, 1, 0);
      chk("R4 one trial", int'(rx_code), 5);
      chk("R10 err cleared", int'(err), 0);
      run_scan(0, 3, 0);
      chk("R4 three trials", int'(rx_code), 7);
      run_scan(0, 0, 0);
      chk("R4 zero trials acts as one", int'(rx_code), 5);
      flaky_rx = -1;

      // R8 R2: two-axis scan with a start pulse mid-scan
      tx_m = win(2, 8);
      rx_m = win(11, 7);
      run_scan(1, 1, 1);
      chk("R8 tx pick", int'(tx_code), 5);
      chk("R8 rx pick", int'(rx_code), 1);
      chk("R2 no restart", int'(busy), 0);

      // R8: coupled axes, second round refines
      couple = 1'b1;
      tx_m = win(2, 5);
      rx_m = win(0, 9);
      run_scan(1, 2, 0);
      chk("R8 coupled tx", int'(tx_code), 3);
      chk("R8 coupled rx", int'(rx_code), 1);
      couple = 1'b0;

      // R9: first (transmit) scan fails in two-axis mode
      tx_m = '0;
      rx_m = '1;
      run_scan(1, 1, 0);
      chk("R9 2D err", int'(err), 1);
      chk("R9 2D tx zero", int'(tx_code), 0);

      // R10: results hold while idle
      tx_m = '1;
      rx_m = win(3, 6);
      run_scan(0, 1, 0);
      repeat (5) begin
         @(posedge clk);
         #1;
      end
      chk("R10 held rx", int'(rx_code), 5);
      chk("R10 held err", int'(err), 0);

      finish_up();
   end

endmodule